// File: doc/BRIEF.md
# Post-Increment Load/Store Address Unit

This unit belongs to the load/store stage of a 32-bit core. It serves memory accesses that use a base register and then advance that register. Memory is addressed with the base value exactly as it was read from the register file. The sum of the base and an offset goes back to the register file as a second write-back result. The offset is chosen per instruction: a sign-extended 12-bit immediate, or the value of a second register. The base always comes from a register.

The unit handles loads and stores of bytes, halfwords and words. It issues a single-cycle memory request with byte enables and with the store data replicated across the lanes. The next cycle it presents two write-back ports. The load port carries the loaded value, extended as the access type asks. The increment port carries the advanced base. A misaligned access raises a flag, issues no memory request and writes back nothing.

Top module: `pinc_lsu`

## Requirements
- R1: A memory request is issued in the same cycle as an accepted operation, and its address equals `base_val` unmodified.
- R2: One cycle after an accepted operation, `inc_we` is high, `inc_idx` equals the operation's `base_idx` and `inc_data` equals base plus offset, modulo 2^32.
- R3: With `op_use_reg` = 1 the offset is `off_reg` and `off_imm` is ignored. With `op_use_reg` = 0 the offset is `off_imm` sign-extended from bit 11, and `off_reg` is ignored.
- R4: One cycle after a load, `ld_we` is high and `ld_idx` equals `dest_idx`. `ld_data` is taken from the little-endian lane that `base_val[1:0]` selects. A byte (`op_size` 00) or halfword (01) result is zero-extended when `op_unsigned` = 1 and sign-extended otherwise. A word (10 or 11) is returned whole.
- R5: A store (`op_store` = 1) raises `mem_we`. Its write data is the byte repeated four times, the halfword repeated twice, or the word. Only the enabled bytes of memory change, and a store never raises `ld_we`.
- R6: `mem_be` is 0001 shifted left by `base_val[1:0]` for a byte, 0011 or 1100 by `base_val[1]` for a halfword, and 1111 for a word.
- R7: A halfword with `base_val[0]` = 1, or a word with `base_val[1:0]` not 00, is misaligned. It issues no memory request. One cycle later it pulses `misalign` with both `ld_we` and `inc_we` low.
- R8: When a load's `dest_idx` equals its `base_idx`, only the load result is written back, and `inc_we` stays low.
- R9: During reset `ld_we`, `inc_we` and `misalign` are low.
- R10: With `op_valid` low there is no memory request, and the next cycle has no write-back and no `misalign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_store | input | 1 | 1 store, 0 load |
| op_size | input | 2 | 00 byte, 01 halfword, 1x word |
| op_unsigned | input | 1 | Zero-extend narrow loads |
| op_use_reg | input | 1 | Offset from register instead of immediate |
| base_val | input | 32 | Base register value |
| base_idx | input | 5 | Base register index |
| dest_idx | input | 5 | Load destination index |
| off_imm | input | 12 | Signed immediate offset |
| off_reg | input | 32 | Register offset |
| st_data | input | 32 | Store source value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| ld_we | output | 1 | Load write-back enable |
| ld_idx | output | 5 | Load write-back index |
| ld_data | output | 32 | Extended load value |
| inc_we | output | 1 | Incremented-base write-back enable |
| inc_idx | output | 5 | Base register index |
| inc_data | output | 32 | Base plus offset |
| misalign | output | 1 | Misaligned access flag |

## Verification
The bench sweeps every byte address of a 64-byte window, each access size, and both extension modes for loads with immediate offsets. This separates lane selection, sign versus zero extension and the alignment rule at every offset within a word. Upper base bits and immediates vary, so the increment sum is checked across carries and negative offsets. A second pass with register offsets and a junk immediate tells the two offset sources apart. Stores over the same window, followed by a whole-word readback, show that only the enabled bytes changed and that misaligned stores left memory untouched. Loads whose destination matches the base expose the write-back priority.

// File: rtl/pinc_lsu.sv
module pinc_lsu #(
  parameter int IMM_W  = 12,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic              op_unsigned,
  input  logic              op_use_reg,
  input  logic [31:0]       base_val,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] dest_idx,
  input  logic [IMM_W-1:0]  off_imm,
  input  logic [31:0]       off_reg,
  input  logic [31:0]       st_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_we,
  output logic [RIDX_W-1:0] ld_idx,
  output logic [31:0]       ld_data,
  output logic              inc_we,
  output logic [RIDX_W-1:0] inc_idx,
  output logic [31:0]       inc_data,
  output logic              misalign
);

  localparam int EXT_W = 32 - IMM_W;

  logic [31:0] offset;
  logic        is_byte, is_half, is_word, mis_now, go;

  assign offset  = op_use_reg ? off_reg : {{EXT_W{off_imm[IMM_W-1]}}, off_imm};
  assign is_byte = (op_size == 2'b00);
  assign is_half = (op_size == 2'b01);
  assign is_word = op_size[1];
  assign mis_now = (is_half & base_val[0]) | (is_word & (|base_val[1:0]));
  assign go      = op_valid & ~mis_now;

  assign mem_req  = go;
  assign mem_we   = go & op_store;
  assign mem_addr = base_val;

  always_comb begin
    if (is_byte) begin
      mem_be    = 4'b0001 << base_val[1:0];
      mem_wdata = {4{st_data[7:0]}};
    end else if (is_half) begin
      mem_be    = base_val[1] ? 4'b1100 : 4'b0011;
      mem_wdata = {2{st_data[15:0]}};
    end else begin
      mem_be    = 4'b1111;
      mem_wdata = st_data;
    end
  end

  logic              r_go, r_ld, r_mis, r_uns;
  logic [1:0]        r_size, r_lo;
  logic [RIDX_W-1:0] r_dest, r_bidx;
  logic [31:0]       r_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_go   <= 1'b0;
      r_ld   <= 1'b0;
      r_mis  <= 1'b0;
      r_uns  <= 1'b0;
      r_size <= 2'b00;
      r_lo   <= 2'b00;
      r_dest <= '0;
      r_bidx <= '0;
      r_inc  <= '0;
    end else begin
      r_go   <= go;
      r_ld   <= go & ~op_store;
      r_mis  <= op_valid & mis_now;
      r_uns  <= op_unsigned;
      r_size <= op_size;
      r_lo   <= base_val[1:0];
      r_dest <= dest_idx;
      r_bidx <= base_idx;
      r_inc  <= base_val + offset;
    end
  end

  logic [31:0] lane;
  assign lane = mem_rdata >> {r_lo, 3'b000};

  always_comb begin
    case (r_size)
      2'b00:   ld_data = r_uns ? {24'd0, lane[7:0]}  : {{24{lane[7]}}, lane[7:0]};
      2'b01:   ld_data = r_uns ? {16'd0, lane[15:0]} : {{16{lane[15]}}, lane[15:0]};
      default: ld_data = mem_rdata;
    endcase
  end

  assign ld_we    = r_ld;
  assign ld_idx   = r_dest;
  assign inc_we   = r_go & ~(r_ld & (r_dest == r_bidx));
  assign inc_idx  = r_bidx;
  assign inc_data = r_inc;
  assign misalign = r_mis;

  p_misalign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!ld_we && !inc_we));

  p_misalign_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !mem_req) |=> misalign);

  p_store_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!ld_we && inc_we));

  p_wb_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we || inc_we) |-> $past(mem_req));

  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && inc_we) |-> (ld_idx != inc_idx));

  p_byte_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_size == 2'b00) |-> ($countones(mem_be) == 1));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!ld_we && !inc_we && !misalign));

endmodule

// File: tb/tb_pinc_lsu.sv
module tb_pinc_lsu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_store = 0, op_unsigned = 0, op_use_reg = 0;
  logic [1:0] op_size = 0;
  logic [31:0] base_val = 0, off_reg = 0, st_data = 0, mem_rdata = 0;
  logic [4:0] base_idx = 0, dest_idx = 0;
  logic [11:0] off_imm = 0;
  logic mem_req, mem_we, ld_we, inc_we, misalign;
  logic [31:0] mem_addr, mem_wdata, ld_data, inc_data;
  logic [3:0] mem_be;
  logic [4:0] ld_idx, inc_idx;

  pinc_lsu dut (.clk, .rst_n, .op_valid, .op_store, .op_size, .op_unsigned, .op_use_reg,
    .base_val, .base_idx, .dest_idx, .off_imm, .off_reg, .st_data, .mem_req, .mem_we,
    .mem_addr, .mem_be, .mem_wdata, .mem_rdata, .ld_we, .ld_idx, .ld_data, .inc_we,
    .inc_idx, .inc_data, .misalign);

  always #10 clk = ~clk;

  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[{mem_addr[5:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= {mem[{mem_addr[5:2], 2'd3}], mem[{mem_addr[5:2], 2'd2}],
                      mem[{mem_addr[5:2], 2'd1}], mem[{mem_addr[5:2], 2'd0}]};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit st, input logic [1:0] sz, input bit uns, input bit ureg,
                        input logic [31:0] base, input logic [4:0] bidx, input logic [4:0] didx,
                        input logic [11:0] imm, input logic [31:0] roff, input logic [31:0] sd);
    logic [31:0] off, exp_ld, exp_wd;
    logic [3:0] exp_be;
    logic [5:0] wa;
    bit mis, exp_inc;
    @(negedge clk);
    op_valid = 1; op_store = st; op_size = sz; op_unsigned = uns; op_use_reg = ureg;
    base_val = base; base_idx = bidx; dest_idx = didx; off_imm = imm; off_reg = roff; st_data = sd;
    off = ureg ? roff : {{20{imm[11]}}, imm};
    mis = (sz == 2'b01 && base[0]) || (sz[1] && base[1:0] != 2'b00);
    wa = {base[5:2], 2'b00};
    if (sz == 2'b00) begin
      exp_be = 4'b0001 << base[1:0]; exp_wd = {4{sd[7:0]}};
      exp_ld = uns ? {24'd0, shadow[base[5:0]]} : {{24{shadow[base[5:0]][7]}}, shadow[base[5:0]]};
    end else if (sz == 2'b01) begin
      exp_be = base[1] ? 4'b1100 : 4'b0011; exp_wd = {2{sd[15:0]}};
      exp_ld = {16'd0, shadow[wa + {base[1], 1'b1}], shadow[wa + {base[1], 1'b0}]};
      if (!uns) exp_ld[31:16] = {16{exp_ld[15]}};
    end else begin
      exp_be = 4'b1111; exp_wd = sd;
      exp_ld = {shadow[wa + 3], shadow[wa + 2], shadow[wa + 1], shadow[wa]};
    end
    #1;
    chk("R7 request suppression", 32'(mem_req), 32'(!mis));
    if (!mis) begin
      chk("R1 address", mem_addr, base);
      chk("R5 write enable", 32'(mem_we), 32'(st));
      chk("R6 byte enables", 32'(mem_be), 32'(exp_be));
      if (st) begin
        chk("R5 write data", mem_wdata, exp_wd);
        for (int b = 0; b < 4; b++) if (exp_be[b]) shadow[wa + 6'(b)] = exp_wd[8*b +: 8];
      end
    end
    @(negedge clk);
    op_valid = 0;
    #1;
    exp_inc = !mis && !(!st && didx == bidx);
    chk("R7 misalign flag", 32'(misalign), 32'(mis));
    chk("R4 load write enable", 32'(ld_we), 32'(!mis && !st));
    chk("R8 increment write enable", 32'(inc_we), 32'(exp_inc));
    if (exp_inc) begin
      chk(ureg ? "R3 register offset sum" : "R2 immediate offset sum", inc_data, base + off);
      chk("R2 increment index", 32'(inc_idx), 32'(bidx));
    end
    if (!mis && !st) begin
      chk("R4 load data", ld_data, exp_ld);
      chk("R4 load index", 32'(ld_idx), 32'(didx));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 64; j++) begin
      mem[j] = 8'(j * 29 + 8'h73);
      shadow[j] = 8'(j * 29 + 8'h73);
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset ld_we", 32'(ld_we), 0);
    chk("R9 reset inc_we", 32'(inc_we), 0);
    chk("R9 reset misalign", 32'(misalign), 0);
    @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 3; s++)
        for (int u = 0; u < 2; u++)
          run_op(0, 2'(s), u[0], 0, {26'(a * 977 + s * 31 + u * 40503), 6'(a)}, 5'(a),
                 (a % 5 == 0) ? 5'(a) : 5'(a + 1), 12'(a * 113 + s * 7 + u * 2049), 32'hDEAD_BEEF, 0);
    for (int i = 0; i < 32; i++)
      run_op(0, 2'(i % 3), i[0], 1, {26'(i * 12345), 6'(i * 4)}, 5'(i), 5'(31 - i),
             12'hFFF, 32'(i * 32'h0123_4567) ^ 32'h8000_0000, 0);
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 3; s++)
        run_op(1, 2'(s), 0, a[0], {26'(a * 3 + s), 6'(a)}, 5'(a), 5'(a),
               12'(a * 77), 32'(-a * 4), (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96 ^ 32'(s));
    for (int w = 0; w < 16; w++)
      run_op(0, 2'b10, 0, 0, 32'(w * 4), 5'd1, 5'd2, 12'd4, 0, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_valid = 0; op_size = 2'(k); base_val = 32'(k * 4); op_store = k[0];
      #1;
      chk("R10 idle no request", 32'(mem_req), 0);
      @(negedge clk);
      #1;
      chk("R10 idle no write-back", 32'({ld_we, inc_we, misalign}), 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule